// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block services translation misses by walking a two-level page table held in memory. A miss arrives with a 32-bit virtual address, an access-type flag and the current table base and table length settings. The walker checks the first-level index against the length setting, then reads the first-level entry and the second-level entry through a single-outstanding request/response memory port. It returns either a frame number with its protection bits, ready to be installed in a translation cache, or a fault code.

Pages are 1 KB, so the low 10 address bits are the page offset and take no part in the walk. The 22-bit page number is split into a 12-bit first-level index (the upper part) and a 10-bit second-level index. Each table entry is one 32-bit word. The walker handles one miss at a time and refuses new misses until the current result has been delivered.

Top module: `ptw_two_level`

## Requirements
- R1: After reset, and whenever no walk is in progress, `miss_ready` is 1 and both `res_valid` and `mem_req_valid` are 0.
- R2: The first-level index is `miss_va[31:20]` and the second-level index is `miss_va[19:10]`. `miss_va[9:0]` has no effect on the result.
- R3: If the first-level index is greater than or equal to `ptlr`, the result arrives in the cycle after the miss is accepted. It carries fault code 1, and no memory read is issued.
- R4: The first-level entry is read at `ptbr + 4*index1`. The second-level entry is read at `{entry1[31:10], 10'b0} + 4*index2`.
- R5: In every table entry, bit 0 is the valid flag, bits [2:1] are the protection bits and bits [31:10] hold a frame number. Bits [9:3] are ignored.
- R6: A first-level entry with bit 0 clear ends the walk with fault code 2, after exactly one memory read.
- R7: A second-level entry with bit 0 clear ends the walk with fault code 3, after exactly two memory reads.
- R8: A successful walk returns fault code 0, `res_frame` equal to bits [31:10] of the second-level entry and `res_prot` equal to its bits [2:1]. On any fault, `res_frame` and `res_prot` are 0. `res_write` echoes the access type of the miss in both cases.
- R9: From the cycle after a miss is accepted until the result has been delivered, `miss_ready` is 0. A miss presented during that time is ignored and produces no result.
- R10: `res_valid` is a single-cycle pulse. A memory request whose `mem_req_ready` is low keeps `mem_req_valid` high and its address unchanged.
- R11: No new memory request is raised while an earlier one is waiting for its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle and able to accept a miss |
| miss_va | input | 32 | Virtual address that missed |
| miss_write | input | 1 | Access type of the miss (1 = write) |
| ptbr | input | 32 | Byte address of the first-level table |
| ptlr | input | 13 | Number of valid first-level entries |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry read from memory |
| res_valid | output | 1 | Result pulse |
| res_write | output | 1 | Access type echoed from the miss |
| res_frame | output | 22 | Physical frame number |
| res_prot | output | 2 | Protection bits of the final entry |
| res_fault | output | 2 | 0 none, 1 length, 2 first-level invalid, 3 second-level invalid |

## Verification
The assertions assume the memory side is well behaved. It returns exactly one response for every accepted request and never returns a response without one. They also assume `ptbr` and `ptlr` are only meaningful when a miss is accepted. The bench memory model honours this: it answers each accepted read one cycle later, keeps at most one read open, and can insert stalls on `mem_req_ready`. The bench drops `miss_valid` right after each handshake, except in the deliberate busy test. Table settings change only between walks.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_OUT,
      ST_WT_OUT,
      ST_RD_IN,
      ST_WT_IN,
      ST_DONE,
      ST_FAULT
   } walk_state_e;

   localparam int FLT_W = 2;
   localparam logic [FLT_W-1:0] FLT_NONE  = 2'd0;
   localparam logic [FLT_W-1:0] FLT_LEN   = 2'd1;
   localparam logic [FLT_W-1:0] FLT_OUTER = 2'd2;
   localparam logic [FLT_W-1:0] FLT_INNER = 2'd3;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
   parameter int VA_W    = 32,
   parameter int OFF_W   = 10,
   parameter int OUTER_W = 12,
   localparam int INNER_W = VA_W - OFF_W - OUTER_W,
   localparam int LEN_W   = OUTER_W + 1
) (
   input  logic [VA_W-1:0]    va,
   input  logic [LEN_W-1:0]   tbl_len,
   output logic [OUTER_W-1:0] outer_idx,
   output logic [INNER_W-1:0] inner_idx,
   output logic               len_bad
);

   logic unused_off;

   assign outer_idx  = va[VA_W-1 -: OUTER_W];
   assign inner_idx  = va[OFF_W +: INNER_W];
   assign len_bad    = {1'b0, outer_idx} >= tbl_len;
   assign unused_off = ^va[OFF_W-1:0];

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
   parameter int PA_W        = 32,
   parameter int IDX_W       = 12,
   parameter int ENTRY_BYTES = 4
) (
   input  logic [PA_W-1:0]  base,
   input  logic [IDX_W-1:0] idx,
   output logic [PA_W-1:0]  addr
);

   localparam bit POW2 = (ENTRY_BYTES & (ENTRY_BYTES - 1)) == 0;
   localparam int SH   = $clog2(ENTRY_BYTES);

   generate
      if (POW2) begin : g_shift
         assign addr = base + (PA_W'(idx) << SH);
      end else begin : g_mult
         assign addr = base + PA_W'(idx) * PA_W'(ENTRY_BYTES);
      end
   endgenerate

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
   parameter int ENTRY_W = 32,
   parameter int PA_W    = 32,
   parameter int OFF_W   = 10,
   parameter int PROT_W  = 2,
   localparam int FRAME_W = PA_W - OFF_W
) (
   input  logic [ENTRY_W-1:0] entry,
   output logic               valid,
   output logic [PROT_W-1:0]  prot,
   output logic [FRAME_W-1:0] frame,
   output logic [PA_W-1:0]    next_base
);

   logic unused_gap;

   assign valid      = entry[0];
   assign prot       = entry[PROT_W:1];
   assign frame      = entry[ENTRY_W-1 -: FRAME_W];
   assign next_base  = {frame, {OFF_W{1'b0}}};
   assign unused_gap = ^entry;

endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
   import ptw_pkg::*;
#(
   parameter int OUTER_W = 12,
   parameter int INNER_W = 10,
   parameter int PA_W    = 32,
   parameter int FRAME_W = 22,
   parameter int PROT_W  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               miss_valid,
   input  logic               miss_write,
   input  logic [OUTER_W-1:0] outer_idx,
   input  logic [INNER_W-1:0] inner_idx,
   input  logic               len_bad,
   input  logic [PA_W-1:0]    tbl_base,
   input  logic               mem_req_ready,
   input  logic               mem_rsp_valid,
   input  logic               ent_valid,
   input  logic [PROT_W-1:0]  ent_prot,
   input  logic [FRAME_W-1:0] ent_frame,
   input  logic [PA_W-1:0]    ent_next_base,
   output logic               miss_ready,
   output logic               mem_req_valid,
   output logic               sel_inner,
   output logic               res_valid,
   output logic               res_write,
   output logic [FRAME_W-1:0] res_frame,
   output logic [PROT_W-1:0]  res_prot,
   output logic [FLT_W-1:0]   res_fault,
   output logic [OUTER_W-1:0] outer_q,
   output logic [INNER_W-1:0] inner_q,
   output logic [PA_W-1:0]    base_q,
   output logic [PA_W-1:0]    lvl2_q
);

   walk_state_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         outer_q   <= '0;
         inner_q   <= '0;
         base_q    <= '0;
         lvl2_q    <= '0;
         res_write <= 1'b0;
         res_frame <= '0;
         res_prot  <= '0;
         res_fault <= FLT_NONE;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (miss_valid) begin
                  outer_q   <= outer_idx;
                  inner_q   <= inner_idx;
                  base_q    <= tbl_base;
                  res_write <= miss_write;
                  res_frame <= '0;
                  res_prot  <= '0;
                  if (len_bad) begin
                     res_fault <= FLT_LEN;
                     state     <= ST_FAULT;
                  end else begin
                     res_fault <= FLT_NONE;
                     state     <= ST_RD_OUT;
                  end
               end
            end
            ST_RD_OUT: if (mem_req_ready) state <= ST_WT_OUT;
            ST_WT_OUT: begin
               if (mem_rsp_valid) begin
                  if (ent_valid) begin
                     lvl2_q <= ent_next_base;
                     state  <= ST_RD_IN;
                  end else begin
                     res_fault <= FLT_OUTER;
                     state     <= ST_FAULT;
                  end
               end
            end
            ST_RD_IN: if (mem_req_ready) state <= ST_WT_IN;
            ST_WT_IN: begin
               if (mem_rsp_valid) begin
                  if (ent_valid) begin
                     res_frame <= ent_frame;
                     res_prot  <= ent_prot;
                     state     <= ST_DONE;
                  end else begin
                     res_fault <= FLT_INNER;
                     state     <= ST_FAULT;
                  end
               end
            end
            ST_DONE:  state <= ST_IDLE;
            ST_FAULT: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign miss_ready    = state == ST_IDLE;
   assign mem_req_valid = (state == ST_RD_OUT) || (state == ST_RD_IN);
   assign sel_inner     = state == ST_RD_IN;
   assign res_valid     = (state == ST_DONE) || (state == ST_FAULT);

endmodule

// File: rtl/ptw_two_level.sv
module ptw_two_level
   import ptw_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int OFF_W       = 10,
   parameter int OUTER_W     = 12,
   parameter int PA_W        = 32,
   parameter int ENTRY_W     = 32,
   parameter int PROT_W      = 2,
   parameter int ENTRY_BYTES = 4,
   localparam int INNER_W = VA_W - OFF_W - OUTER_W,
   localparam int FRAME_W = PA_W - OFF_W,
   localparam int LEN_W   = OUTER_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               miss_valid,
   output logic               miss_ready,
   input  logic [VA_W-1:0]    miss_va,
   input  logic               miss_write,
   input  logic [PA_W-1:0]    ptbr,
   input  logic [LEN_W-1:0]   ptlr,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   output logic               res_valid,
   output logic               res_write,
   output logic [FRAME_W-1:0] res_frame,
   output logic [PROT_W-1:0]  res_prot,
   output logic [FLT_W-1:0]   res_fault
);

   generate
      if (INNER_W < 1) begin : g_bad_split
         $error("ptw_two_level: offset plus outer index leave no inner index");
      end
      if (ENTRY_W < FRAME_W + PROT_W + 1) begin : g_bad_entry
         $error("ptw_two_level: entry too narrow for frame, protection and valid");
      end
      if (ENTRY_BYTES < 1) begin : g_bad_bytes
         $error("ptw_two_level: entry size must be positive");
      end
   endgenerate

   logic [OUTER_W-1:0] outer_idx, outer_q;
   logic [INNER_W-1:0] inner_idx, inner_q;
   logic               len_bad;
   logic [PA_W-1:0]    base_q, lvl2_q, addr_out, addr_in, ent_next_base;
   logic               ent_valid, sel_inner;
   logic [PROT_W-1:0]  ent_prot;
   logic [FRAME_W-1:0] ent_frame;

   ptw_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .OUTER_W(OUTER_W)) u_split (
      .va(miss_va), .tbl_len(ptlr),
      .outer_idx(outer_idx), .inner_idx(inner_idx), .len_bad(len_bad)
   );

   ptw_addr_gen #(.PA_W(PA_W), .IDX_W(OUTER_W), .ENTRY_BYTES(ENTRY_BYTES)) u_addr_out (
      .base(base_q), .idx(outer_q), .addr(addr_out)
   );

   ptw_addr_gen #(.PA_W(PA_W), .IDX_W(INNER_W), .ENTRY_BYTES(ENTRY_BYTES)) u_addr_in (
      .base(lvl2_q), .idx(inner_q), .addr(addr_in)
   );

   ptw_entry_decode #(.ENTRY_W(ENTRY_W), .PA_W(PA_W), .OFF_W(OFF_W), .PROT_W(PROT_W)) u_dec (
      .entry(mem_rsp_data), .valid(ent_valid), .prot(ent_prot),
      .frame(ent_frame), .next_base(ent_next_base)
   );

   ptw_walk_fsm #(
      .OUTER_W(OUTER_W), .INNER_W(INNER_W), .PA_W(PA_W),
      .FRAME_W(FRAME_W), .PROT_W(PROT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .miss_valid(miss_valid), .miss_write(miss_write),
      .outer_idx(outer_idx), .inner_idx(inner_idx), .len_bad(len_bad),
      .tbl_base(ptbr),
      .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
      .ent_valid(ent_valid), .ent_prot(ent_prot), .ent_frame(ent_frame),
      .ent_next_base(ent_next_base),
      .miss_ready(miss_ready), .mem_req_valid(mem_req_valid), .sel_inner(sel_inner),
      .res_valid(res_valid), .res_write(res_write), .res_frame(res_frame),
      .res_prot(res_prot), .res_fault(res_fault),
      .outer_q(outer_q), .inner_q(inner_q), .base_q(base_q), .lvl2_q(lvl2_q)
   );

   assign mem_req_addr = sel_inner ? addr_in : addr_out;

endmodule

// File: rtl/ptw_two_level_chk.sv
module ptw_two_level_chk
   import ptw_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int OUTER_W = 12,
   parameter int PA_W    = 32,
   parameter int FRAME_W = 22,
   parameter int PROT_W  = 2,
   localparam int LEN_W  = OUTER_W + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               miss_valid,
   input logic               miss_ready,
   input logic [VA_W-1:0]    miss_va,
   input logic [LEN_W-1:0]   ptlr,
   input logic               mem_req_valid,
   input logic               mem_req_ready,
   input logic [PA_W-1:0]    mem_req_addr,
   input logic               mem_rsp_valid,
   input logic               res_valid,
   input logic [FRAME_W-1:0] res_frame,
   input logic [PROT_W-1:0]  res_prot,
   input logic [FLT_W-1:0]   res_fault
);

   logic rd_open;

   always_ff @(posedge clk) begin
      if (!rst_n)                          rd_open <= 1'b0;
      else if (mem_req_valid && mem_req_ready) rd_open <= 1'b1;
      else if (mem_rsp_valid)              rd_open <= 1'b0;
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      miss_ready |-> (!mem_req_valid && !res_valid));

   p_len_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready && ({1'b0, miss_va[VA_W-1 -: OUTER_W]} >= ptlr))
      |=> (res_valid && res_fault == FLT_LEN && !mem_req_valid));

   p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault != FLT_NONE) |-> (res_frame == '0 && res_prot == '0));

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> !miss_ready);

   p_res_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   p_one_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_open |-> !mem_req_valid);

endmodule

bind ptw_two_level ptw_two_level_chk #(
   .VA_W(VA_W), .OUTER_W(OUTER_W), .PA_W(PA_W), .FRAME_W(FRAME_W), .PROT_W(PROT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
   .miss_va(miss_va), .ptlr(ptlr), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
   .mem_rsp_valid(mem_rsp_valid), .res_valid(res_valid), .res_frame(res_frame),
   .res_prot(res_prot), .res_fault(res_fault)
);

// File: tb/sim_ptw_two_level.sv
module sim_ptw_two_level;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic        miss_ready;
   logic [31:0] miss_va = '0;
   logic        miss_write = 1'b0;
   logic [31:0] ptbr = 32'h0001_0000;
   logic [12:0] ptlr = 13'd16;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        res_valid;
   logic        res_write;
   logic [21:0] res_frame;
   logic [1:0]  res_prot;
   logic [1:0]  res_fault;

   always #10 clk = ~clk;

   ptw_two_level u0 (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
      .miss_va(miss_va), .miss_write(miss_write), .ptbr(ptbr), .ptlr(ptlr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_write(res_write),
      .res_frame(res_frame), .res_prot(res_prot), .res_fault(res_fault)
   );

   int checks = 0;
   int errors = 0;
   int rd_cnt = 0;
   int res_cnt = 0;
   bit stall_mode = 1'b0;
   bit done = 1'b0;

   logic [31:0] mem [logic [31:0]];
   logic [26:0] exp_q [$];
   string       tag_q [$];

   function automatic logic [31:0] mk(input logic [21:0] f, input logic [1:0] p, input bit v);
      return {f, 7'b0, p, v};
   endfunction

   function automatic logic [31:0] va_of(input logic [11:0] o, input logic [9:0] i, input logic [9:0] off);
      return {o, i, off};
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // memory model: answers each accepted read one cycle later
   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (rst_n && mem_req_valid && mem_req_ready) begin
            rd_cnt++;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
         end else begin
            mem_rsp_valid <= 1'b0;
         end
         mem_req_ready <= stall_mode ? (cyc % 3 == 0) : 1'b1;
      end
   end

   // monitor: compare each result with the next expected item
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "result without accepted miss", {5'b0, res_write, res_frame, res_prot, res_fault}, 32'h0);
            end else begin
               logic [26:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(res_fault == e[1:0], t, "fault", 32'(res_fault), 32'(e[1:0]));
               check(res_frame == e[25:4] && res_prot == e[3:2], t, "frame/prot",
                     {8'b0, res_frame, res_prot}, {8'b0, e[25:4], e[3:2]});
               check(res_write == e[26], t, "write echo (R8)", 32'(res_write), 32'(e[26]));
            end
            res_cnt++;
         end
      end
   end

   task automatic send_miss(input logic [31:0] va, input bit wr);
      @(negedge clk);
      miss_va    = va;
      miss_write = wr;
      miss_valid = 1'b1;
      while (!miss_ready) @(negedge clk);
      @(negedge clk);
      miss_valid = 1'b0;
   endtask

   task automatic run_walk(input logic [31:0] va, input bit wr, input logic [21:0] f,
                           input logic [1:0] p, input logic [1:0] flt, input int reads,
                           input string tag);
      int r0, d0;
      exp_q.push_back({wr, f, p, flt});
      tag_q.push_back(tag);
      r0 = rd_cnt;
      d0 = res_cnt;
      send_miss(va, wr);
      while (res_cnt == d0) @(negedge clk);
      check(rd_cnt - r0 == reads, tag, "memory reads", 32'(rd_cnt - r0), 32'(reads));
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", "run did not complete", 32'h0, 32'h1);
         finish_run();
      end
   end

   initial begin
      // first-level table at 0x10000
      mem[32'h0001_0000] = mk(22'h000100, 2'b00, 1'b1);   // index 0 -> 0x40000
      mem[32'h0001_000C] = mk(22'h000FFC, 2'b11, 1'b0);   // index 3 invalid
      mem[32'h0001_3FFC] = mk(22'h000200, 2'b00, 1'b1);   // index 4095 -> 0x80000
      // second-level table at 0x40000
      mem[32'h0004_0000] = mk(22'h012345, 2'b01, 1'b1);
      mem[32'h0004_0004] = mk(22'h000001, 2'b10, 1'b1) | 32'h0000_03F8; // ignored bits set
      mem[32'h0004_0014] = mk(22'h3FFFFF, 2'b11, 1'b1);
      mem[32'h0004_001C] = 32'hABC0_0006;                 // invalid
      mem[32'h0004_0FFC] = mk(22'h000001, 2'b10, 1'b1);
      mem[32'h0008_0FFC] = mk(22'h2AAAAA, 2'b00, 1'b1);
      // alternate first-level table at 0x20000
      mem[32'h0002_0004] = mk(22'h000300, 2'b00, 1'b1);   // index 1 -> 0xC0000
      mem[32'h000C_0008] = mk(22'h155555, 2'b01, 1'b1);

      repeat (3) @(negedge clk);
      check(miss_ready == 1'b1, "R1", "miss_ready in reset", 32'(miss_ready), 32'h1);
      check(res_valid == 1'b0 && mem_req_valid == 1'b0, "R1", "outputs quiet in reset",
            {30'b0, res_valid, mem_req_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(miss_ready && !res_valid && !mem_req_valid, "R1", "idle after reset",
            {29'b0, miss_ready, res_valid, mem_req_valid}, 32'h4);

      // length faults: fault code 1, no read
      run_walk(va_of(12'd16, 10'd0, 10'd0), 1'b0, 22'h0, 2'b00, 2'd1, 0, "R3");
      run_walk(va_of(12'hFFF, 10'd5, 10'd0), 1'b1, 22'h0, 2'b00, 2'd1, 0, "R3");
      ptlr = 13'd0;
      run_walk(va_of(12'd0, 10'd0, 10'd0), 1'b0, 22'h0, 2'b00, 2'd1, 0, "R3");
      ptlr = 13'd16;
      // last in-range index walks the table (entry absent -> invalid)
      run_walk(va_of(12'd15, 10'd0, 10'd0), 1'b0, 22'h0, 2'b00, 2'd2, 1, "R3");

      // invalid entries
      run_walk(va_of(12'd3, 10'd0, 10'd0), 1'b0, 22'h0, 2'b00, 2'd2, 1, "R6");
      run_walk(va_of(12'd0, 10'd7, 10'd0), 1'b1, 22'h0, 2'b00, 2'd3, 2, "R7");

      // successful walks
      run_walk(va_of(12'd0, 10'd0, 10'h3FF), 1'b0, 22'h012345, 2'b01, 2'd0, 2, "R8");
      run_walk(va_of(12'd0, 10'd0, 10'h155), 1'b1, 22'h012345, 2'b01, 2'd0, 2, "R2");
      run_walk(va_of(12'd0, 10'd5, 10'd0), 1'b0, 22'h3FFFFF, 2'b11, 2'd0, 2, "R8");
      run_walk(va_of(12'd0, 10'd1, 10'd9), 1'b0, 22'h000001, 2'b10, 2'd0, 2, "R5");
      run_walk(va_of(12'd0, 10'd1023, 10'd0), 1'b1, 22'h000001, 2'b10, 2'd0, 2, "R4");
      ptlr = 13'd4096;
      run_walk(va_of(12'hFFF, 10'd1023, 10'd0), 1'b0, 22'h2AAAAA, 2'b00, 2'd0, 2, "R4");
      ptbr = 32'h0002_0000;
      run_walk(va_of(12'd1, 10'd2, 10'd0), 1'b1, 22'h155555, 2'b01, 2'd0, 2, "R4");
      ptbr = 32'h0001_0000;
      ptlr = 13'd16;

      // busy: a second miss during a walk is ignored
      begin
         int d0;
         exp_q.push_back({1'b0, 22'h3FFFFF, 2'b11, 2'd0});
         tag_q.push_back("R9");
         d0 = res_cnt;
         send_miss(va_of(12'd0, 10'd5, 10'd0), 1'b0);
         miss_va    = va_of(12'd16, 10'd0, 10'd0);
         miss_valid = 1'b1;
         for (int k = 0; k < 2; k++) begin
            check(miss_ready == 1'b0, "R9", "miss_ready while busy", 32'(miss_ready), 32'h0);
            @(negedge clk);
         end
         miss_valid = 1'b0;
         while (res_cnt == d0) @(negedge clk);
         repeat (6) @(negedge clk);
         check(res_cnt == d0 + 1, "R9", "results for busy-time miss", 32'(res_cnt - d0), 32'h1);
      end

      // memory back-pressure
      stall_mode = 1'b1;
      run_walk(va_of(12'd0, 10'd5, 10'd0), 1'b1, 22'h3FFFFF, 2'b11, 2'd0, 2, "R10");
      run_walk(va_of(12'd0, 10'd7, 10'd0), 1'b0, 22'h0, 2'b00, 2'd3, 2, "R11");
      run_walk(va_of(12'd3, 10'd0, 10'd0), 1'b0, 22'h0, 2'b00, 2'd2, 1, "R10");
      stall_mode = 1'b0;

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R10", "pending expected results", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      finish_run();
   end

endmodule